// File: doc/BRIEF.md
# Word-Window I2C Master

This block is a single-bus I2C master that moves packets of up to 255 bytes. Payload passes through a 32-bit window that holds four bytes. Writes go from the host to the target and reads come back from the target to the host. The host issues one command per packet. The command carries a 7-bit target address, a byte count, a read flag and an end-of-packet choice. That choice either finishes the packet with STOP or leaves the bus parked. A parked bus has SCL held low, ready for another packet that begins with a repeated START. A stop-only command can also close a parked bus.

Both window directions use valid/ready handshakes, and the master paces the bus against them.

- **Write window.** `wr_ready` is high whenever the window is empty. One beat on `wr_valid`/`wr_ready` loads a word. A write packet's first word should be loaded before its command. Each later word is accepted as soon as the engine has taken the previous one. If the next word has not arrived, the master holds SCL low and waits.
- **Read window.** `rd_valid` rises when four bytes, or the final partial group, are ready. `rd_data` then stays stable until the beat completes on `rd_ready`. The master holds SCL low until that beat happens.
- **Control and status.** The command uses `cmd_valid`/`cmd_ready`. `active`, `parked` and `nack_err` are plain level outputs.

Within each word the bytes are little-endian: bits 7:0 go on the bus first. Each byte travels MSB first.

Top module: `i2cw_master`

## Requirements
- R1: After reset `scl_oe` and `sda_oe` are 0 and the bus is released. `active`, `parked`, `rd_valid` and `nack_err` are 0, while `cmd_ready` and `wr_ready` are 1.
- R2: A write packet sends START and then the byte {address, 0}. It then sends the payload bytes in order. Byte k of each window word (bits 8k+7:8k) is sent after byte k-1, and each byte goes MSB first.
- R3: `wr_ready` is 0 while the window holds a word the engine has not taken. Such a word is never overwritten or dropped, except by the flush in R8. A packet of N bytes uses ceil(N/4) words, and only the low ((N-1) mod 4)+1 bytes of the last word are sent.
- R4: A read packet sends START and then {address, 1}. Received bytes are packed little-endian into `rd_data`. `rd_valid` is raised after each group of four and after the final partial group, with the unused upper bytes zero. `rd_valid` and `rd_data` stay unchanged until `rd_ready`.
- R5: On a read the master ACKs (SDA low) every byte except the last one of the count. It NACKs the last byte (SDA released).
- R6: With `cmd_stop`=0 no STOP is generated. After the packet, `parked`=1, `active`=0 and SCL is held low. The next command starts with a repeated START.
- R7: A command with `cmd_len`=0 and `cmd_stop`=1, accepted while parked, produces only a STOP and leaves the block idle (`parked`=0).
- R8: If the target NACKs the address or a write byte, the packet ends with STOP and `nack_err` is set. `nack_err` stays set until the next command is accepted. Any word left in the write window is flushed, so `wr_ready` is 1 once the packet ends.
- R9: `cmd_ready` is 1 only when idle or parked. `active` is 1 from command acceptance until the packet has finished.
- R10: SCL runs with a period of 4·Q clock cycles. Q = CLK_HZ/(4·SCL_HZ), with a minimum of 2. The default is 100 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_addr | input | 7 | Target address |
| cmd_len | input | LEN_W | Payload byte count |
| cmd_read | input | 1 | 1 = read packet, 0 = write packet |
| cmd_stop | input | 1 | 1 = end with STOP, 0 = park the bus |
| wr_valid | input | 1 | Write window word valid |
| wr_ready | output | 1 | Write window empty |
| wr_data | input | 32 | Write word, byte 0 in bits 7:0 |
| rd_valid | output | 1 | Read word valid |
| rd_ready | input | 1 | Host takes the read word |
| rd_data | output | 32 | Read word, byte 0 in bits 7:0 |
| active | output | 1 | Packet in progress |
| parked | output | 1 | Bus held in wait phase |
| nack_err | output | 1 | Sticky target NACK flag |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The bench builds the block with CLK_HZ = 250 MHz and SCL_HZ = 12.5 MHz. That gives a quarter period of 5 cycles and a 20-cycle SCL period, so a byte takes about 180 clocks. This makes dozens of multi-word packets, parks, repeated STARTs and NACK aborts affordable in one run. LEN_W keeps its default of 8. The random lengths of 1 to 12 reach every partial-group size, in both directions and across word boundaries.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_STOP  = 2'd1,
    BOP_BIT   = 2'd2
  } bop_e;

  typedef enum logic [2:0] {
    C_IDLE, C_START, C_TX, C_WLOAD, C_RX, C_RHOLD, C_STOP, C_PARK
  } cst_e;

  localparam int unsigned WIN_BYTES = 4;
  localparam int unsigned WIN_W     = 8 * WIN_BYTES;
endpackage

// File: rtl/i2cw_tick.sv
module i2cw_tick #(
  parameter int unsigned QTR = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (QTR > 2) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(QTR - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R10
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2cw_bit.sv
module i2cw_bit
  import i2cw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic op_valid,
  input  bop_e op,
  input  logic op_tx,
  input  logic sda_s,
  output logic done,
  output logic rx,
  output logic scl_oe,
  output logic sda_oe
);
  logic       busy;
  logic [1:0] ph;
  bop_e       cur;
  logic       txb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ph     <= 2'd0;
      cur    <= BOP_START;
      txb    <= 1'b1;
      done   <= 1'b0;
      rx     <= 1'b1;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (op_valid) begin
          busy <= 1'b1;
          cur  <= op;
          txb  <= op_tx;
          ph   <= 2'd0;
        end
      end else if (tick) begin
        ph <= ph + 2'd1;
        case (cur)
          BOP_START: begin
            case (ph)
              2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b0; end
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: scl_oe <= 1'b1;
            endcase
          end
          BOP_STOP: begin
            case (ph)
              2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b1; end
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: ;
            endcase
          end
          default: begin
            case (ph)
              2'd0: begin scl_oe <= 1'b1; sda_oe <= ~txb; end
              2'd1: scl_oe <= 1'b0;
              2'd2: rx <= sda_s;
              default: scl_oe <= 1'b1;
            endcase
          end
        endcase
        if (ph == 2'd3) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2
  sda_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur == BOP_BIT && !scl_oe) |=> $stable(sda_oe));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_read,
  input  logic             cmd_stop,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIN_W-1:0] wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIN_W-1:0] rd_data,
  output logic             active,
  output logic             parked,
  output logic             nack_err,
  output logic             op_valid,
  output bop_e             op,
  output logic             op_tx,
  input  logic             op_done,
  input  logic             op_rx
);
  cst_e             st;
  logic [6:0]       addr_q;
  logic             rd_q, stop_q;
  logic [LEN_W-1:0] left;
  logic [1:0]       bi;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic [WIN_W-1:0] win, wbuf, rbuf;
  logic             win_full, pend, is_addr, rvld;

  assign cmd_ready = (st == C_IDLE) || (st == C_PARK);
  assign wr_ready  = !win_full;
  assign rd_valid  = rvld;
  assign rd_data   = rbuf;
  assign active    = !cmd_ready;
  assign parked    = (st == C_PARK);

  wire  take_cmd  = cmd_valid && cmd_ready;
  wire  last_byte = (left == LEN_W'(1));
  cst_e end_st;
  assign end_st = stop_q ? C_STOP : C_PARK;

  always_comb begin
    op_valid = 1'b0;
    op       = BOP_BIT;
    op_tx    = 1'b1;
    if (!pend) begin
      case (st)
        C_START: begin op_valid = 1'b1; op = BOP_START; end
        C_STOP:  begin op_valid = 1'b1; op = BOP_STOP; end
        C_TX:    begin op_valid = 1'b1; op_tx = bitn[3] ? 1'b1 : sh[7]; end
        C_RX:    begin op_valid = 1'b1; op_tx = bitn[3] ? last_byte : 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= C_IDLE;
      addr_q   <= '0;
      rd_q     <= 1'b0;
      stop_q   <= 1'b1;
      left     <= '0;
      bi       <= 2'd0;
      bitn     <= 4'd0;
      sh       <= 8'd0;
      win      <= '0;
      wbuf     <= '0;
      rbuf     <= '0;
      win_full <= 1'b0;
      pend     <= 1'b0;
      is_addr  <= 1'b0;
      rvld     <= 1'b0;
      nack_err <= 1'b0;
    end else begin
      if (op_valid) pend <= 1'b1;
      if (op_done)  pend <= 1'b0;
      if (wr_valid && wr_ready) begin
        win      <= wr_data;
        win_full <= 1'b1;
      end
      if (rvld && rd_ready) rvld <= 1'b0;

      case (st)
        C_IDLE, C_PARK: begin
          if (cmd_valid) begin
            addr_q   <= cmd_addr;
            rd_q     <= cmd_read;
            stop_q   <= cmd_stop;
            left     <= cmd_len;
            bi       <= 2'd0;
            nack_err <= 1'b0;
            st <= (st == C_PARK && cmd_len == '0 && cmd_stop) ? C_STOP : C_START;
          end
        end
        C_START: if (op_done) begin
          sh      <= {addr_q, rd_q};
          bitn    <= 4'd0;
          is_addr <= 1'b1;
          st      <= C_TX;
        end
        C_TX: if (op_done) begin
          if (!bitn[3]) begin
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn + 4'd1;
          end else if (op_rx) begin
            nack_err <= 1'b1;
            st       <= C_STOP;
          end else if (is_addr) begin
            is_addr <= 1'b0;
            bitn    <= 4'd0;
            if (left == '0)  st <= end_st;
            else if (rd_q)   st <= C_RX;
            else             st <= C_WLOAD;
          end else begin
            left <= left - 1'b1;
            bi   <= bi + 2'd1;
            st   <= last_byte ? end_st : C_WLOAD;
          end
        end
        C_WLOAD: begin
          if (bi == 2'd0) begin
            if (win_full) begin
              wbuf     <= win;
              sh       <= win[7:0];
              win_full <= 1'b0;
              bitn     <= 4'd0;
              st       <= C_TX;
            end
          end else begin
            sh   <= wbuf[{bi, 3'b000} +: 8];
            bitn <= 4'd0;
            st   <= C_TX;
          end
        end
        C_RX: if (op_done) begin
          if (!bitn[3]) begin
            sh   <= {sh[6:0], op_rx};
            bitn <= bitn + 4'd1;
          end else begin
            if (bi == 2'd0) rbuf <= {{(WIN_W-8){1'b0}}, sh};
            else            rbuf[{bi, 3'b000} +: 8] <= sh;
            left <= left - 1'b1;
            bi   <= bi + 2'd1;
            bitn <= 4'd0;
            if (bi == 2'd3 || last_byte) begin
              rvld <= 1'b1;
              st   <= C_RHOLD;
            end
          end
        end
        C_RHOLD: if (!rvld) begin
          if (left == '0) st <= end_st;
          else            st <= C_RX;
        end
        C_STOP: if (op_done) begin
          st <= C_IDLE;
          if (nack_err) win_full <= 1'b0;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R3
  win_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && st != C_WLOAD && st != C_STOP) |=> !wr_ready);

  // R8
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_err && !take_cmd) |=> nack_err);

  // R9
  cmd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd |=> active);
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
  import i2cw_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned SCL_HZ = 100_000,
  parameter int unsigned LEN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_read,
  input  logic             cmd_stop,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [31:0]      wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [31:0]      rd_data,
  output logic             active,
  output logic             parked,
  output logic             nack_err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);
  localparam int unsigned QTR_RAW = CLK_HZ / (4 * SCL_HZ);
  localparam int unsigned QTR     = (QTR_RAW < 2) ? 2 : QTR_RAW;

  logic [1:0] sda_sync;
  logic       tick, op_valid, op_tx, op_done, op_rx;
  bop_e       op;

  always_ff @(posedge clk) begin
    if (!rst_n) sda_sync <= 2'b11;
    else        sda_sync <= {sda_sync[0], sda_i};
  end

  i2cw_tick #(.QTR(QTR)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  i2cw_bit u_bit (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .op_valid(op_valid), .op(op), .op_tx(op_tx), .sda_s(sda_sync[1]),
    .done(op_done), .rx(op_rx), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2cw_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_read(cmd_read), .cmd_stop(cmd_stop),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .active(active), .parked(parked), .nack_err(nack_err),
    .op_valid(op_valid), .op(op), .op_tx(op_tx),
    .op_done(op_done), .op_rx(op_rx)
  );

  // R6
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> scl_oe);

  // R1
  idle_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !parked) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/sim_i2cw_master.sv
`timescale 1ns/1ps
module sim_i2cw_master;
  localparam int T_IDLE = 0, T_ADDR = 1, T_WR = 2, T_RD = 3;
  localparam logic [6:0] TADDR = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_read = 0, cmd_stop = 0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_len = '0;
  logic wr_valid = 0, rd_ready = 0;
  logic [31:0] wr_data = '0;
  logic cmd_ready, wr_ready, rd_valid, active, parked, nack_err, scl_oe, sda_oe;
  logic [31:0] rd_data;

  logic t_oe;
  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | t_oe);

  always #2 clk = ~clk;

  i2cw_master #(.CLK_HZ(250_000_000), .SCL_HZ(12_500_000), .LEN_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_read(cmd_read), .cmd_stop(cmd_stop),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .active(active), .parked(parked), .nack_err(nack_err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_l)
  );

  int nchk = 0, nerr = 0;
  int rseed = 17;
  int nack_at = -1;
  logic [7:0] wb [0:15];

  function automatic logic [7:0] rpat(input int s, input int i);
    return 8'(s + i * 29 + (i >> 1));
  endfunction

  // ---------------- behavioural target ----------------
  int ts, bc, wi, ri, tn, mn, starts, stops;
  logic psc, psd, tack, macked;
  logic [7:0] tsh, last_ab;
  logic [7:0] tlog [0:511];
  logic       mack [0:511];
  wire [7:0] cur_rb   = rpat(rseed, ri);
  wire [7:0] nxt_rb   = rpat(rseed, ri + 1);
  wire [7:0] first_rb = rpat(rseed, 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      ts <= T_IDLE; bc <= 0; wi <= 0; ri <= 0; tn <= 0; mn <= 0;
      starts <= 0; stops <= 0; psc <= 1'b1; psd <= 1'b1; t_oe <= 1'b0;
      tack <= 1'b0; macked <= 1'b0; tsh <= 8'd0; last_ab <= 8'd0;
    end else begin
      psc <= scl_l; psd <= sda_l;
      if (scl_l && psc && psd && !sda_l) begin
        ts <= T_ADDR; bc <= 0; t_oe <= 1'b0; starts <= starts + 1;
      end else if (scl_l && psc && !psd && sda_l) begin
        ts <= T_IDLE; t_oe <= 1'b0; stops <= stops + 1;
      end else if (scl_l && !psc) begin
        if ((ts == T_ADDR || ts == T_WR) && bc < 8) begin
          tsh <= {tsh[6:0], sda_l}; bc <= bc + 1;
        end else if (ts == T_RD) begin
          if (bc < 8) bc <= bc + 1;
          else if (bc == 9) begin
            mack[mn] <= sda_l; mn <= mn + 1; macked <= !sda_l; bc <= 10;
          end
        end
      end else if (!scl_l && psc) begin
        if (ts == T_ADDR || ts == T_WR) begin
          if (bc == 8) begin
            if (ts == T_ADDR) begin
              tack <= (tsh[7:1] == TADDR); t_oe <= (tsh[7:1] == TADDR);
              last_ab <= tsh;
            end else begin
              tack <= (wi != nack_at); t_oe <= (wi != nack_at);
              tlog[tn] <= tsh; tn <= tn + 1; wi <= wi + 1;
            end
            bc <= 9;
          end else if (bc == 9) begin
            t_oe <= 1'b0; bc <= 0;
            if (!tack) ts <= T_IDLE;
            else if (ts == T_ADDR) begin
              if (tsh[0]) begin ts <= T_RD; ri <= 0; t_oe <= ~first_rb[7]; end
              else begin ts <= T_WR; wi <= 0; end
            end
          end
        end else if (ts == T_RD) begin
          if (bc >= 1 && bc < 8) t_oe <= ~cur_rb[7 - bc];
          else if (bc == 8) begin t_oe <= 1'b0; bc <= 9; end
          else if (bc == 10) begin
            if (macked) begin ri <= ri + 1; t_oe <= ~nxt_rb[7]; bc <= 0; end
            else begin ts <= T_IDLE; t_oe <= 1'b0; end
          end
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wword(input int k);
    return {wb[4*k+3], wb[4*k+2], wb[4*k+1], wb[4*k]};
  endfunction

  task automatic issue(input logic [6:0] a, input int len, input bit rd, input bit stp);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_addr = a; cmd_len = 8'(len); cmd_read = rd; cmd_stop = stp;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (active) @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic do_write(input logic [6:0] a, input int len, input bit stp, input bit meas);
    int words, g;
    words = (len + 3) / 4;
    if (len > 0) push(wword(0));
    issue(a, len, 1'b0, stp);
    if (meas) begin
      // R10: two consecutive SCL rises during the address byte
      while (!scl_oe) @(negedge clk);
      while (scl_oe) @(negedge clk);
      g = 0;
      while (!scl_oe) begin @(negedge clk); g++; end
      while (scl_oe) begin @(negedge clk); g++; end
      chk("R10 scl period", 32'(g), 32'd20);
    end
    for (int k = 1; k < words; k++) begin
      while (!wr_ready && active) @(negedge clk);
      if (!active) break;
      wr_valid = 1; wr_data = wword(k);
      @(negedge clk);
      wr_valid = 0;
    end
    wait_idle();
  endtask

  task automatic check_write(input int len, input int tn0, input logic [6:0] a);
    chk("R2 address byte", {24'd0, last_ab}, {24'd0, a, 1'b0});
    chk("R3 byte count", 32'(tn - tn0), 32'(len));
    for (int i = 0; i < len; i++)
      chk("R2 payload byte", {24'd0, tlog[tn0 + i]}, {24'd0, wb[i]});
  endtask

  task automatic do_read(input logic [6:0] a, input int len, input bit stp);
    int words, mn0, nb;
    logic [31:0] exp;
    words = (len + 3) / 4;
    mn0 = mn;
    issue(a, len, 1'b1, stp);
    for (int k = 0; k < words; k++) begin
      while (!rd_valid) @(negedge clk);
      repeat ($urandom % 12) @(negedge clk);
      nb = (len - 4 * k > 4) ? 4 : len - 4 * k;
      exp = '0;
      for (int j = 0; j < nb; j++) exp[8*j +: 8] = rpat(rseed, 4 * k + j);
      chk("R4 read word", rd_data, exp);
      rd_ready = 1;
      @(negedge clk);
      rd_ready = 0;
    end
    wait_idle();
    chk("R4 address byte", {24'd0, last_ab}, {24'd0, a, 1'b1});
    chk("R5 ack count", 32'(mn - mn0), 32'(len));
    for (int i = 0; i < len; i++)
      chk("R5 master ack bit", {31'd0, mack[mn0 + i]}, {31'd0, (i == len - 1)});
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int tn0, st0, sp0, len;
    bit rd, stp;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 scl_oe", {31'd0, scl_oe}, 32'd0);
    chk("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 status", {26'd0, active, parked, rd_valid, nack_err, cmd_ready, wr_ready},
        32'b000011);

    // R2 R3 R10: six-byte write with STOP
    for (int i = 0; i < 6; i++) wb[i] = 8'(8'h10 + 8'h11 * i);
    tn0 = tn; sp0 = stops;
    do_write(TADDR, 6, 1'b1, 1'b1);
    check_write(6, tn0, TADDR);
    chk("R2 stop issued", 32'(stops - sp0), 32'd1);

    // R4 R5: seven-byte read
    rseed = 91;
    do_read(TADDR, 7, 1'b1);

    // R6: write parks, then read from park with repeated START
    for (int i = 0; i < 3; i++) wb[i] = 8'($urandom);
    tn0 = tn; sp0 = stops;
    do_write(TADDR, 3, 1'b0, 1'b0);
    check_write(3, tn0, TADDR);
    chk("R6 no stop", 32'(stops - sp0), 32'd0);
    chk("R6 parked", {30'd0, parked, active}, 32'b10);
    repeat (30) @(negedge clk);
    chk("R6 scl held", {31'd0, scl_oe}, 32'd1);
    chk("R9 ready in park", {31'd0, cmd_ready}, 32'd1);
    st0 = starts;
    rseed = 5;
    do_read(TADDR, 2, 1'b1);
    chk("R6 repeated start", 32'(starts - st0), 32'd1);

    // R7: park then stop-only
    wb[0] = 8'hA5; wb[1] = 8'h3C;
    do_write(TADDR, 2, 1'b0, 1'b0);
    st0 = starts; sp0 = stops;
    issue(TADDR, 0, 1'b0, 1'b1);
    wait_idle();
    chk("R7 stop only", 32'(stops - sp0), 32'd1);
    chk("R7 no start", 32'(starts - st0), 32'd0);
    chk("R7 idle", {30'd0, parked, active}, 32'd0);

    // R8: address NACK
    wb[0] = 8'h01; wb[1] = 8'h02; wb[2] = 8'h03; wb[3] = 8'h04;
    tn0 = tn; sp0 = stops;
    do_write(7'h21, 4, 1'b1, 1'b0);
    chk("R8 addr nack err", {31'd0, nack_err}, 32'd1);
    chk("R8 addr nack stop", 32'(stops - sp0), 32'd1);
    chk("R8 no data", 32'(tn - tn0), 32'd0);
    chk("R8 window flushed", {31'd0, wr_ready}, 32'd1);
    repeat (20) @(negedge clk);
    chk("R8 err sticky", {31'd0, nack_err}, 32'd1);

    // R8: data NACK at byte 5 of 9, then recovery clears flag
    for (int i = 0; i < 9; i++) wb[i] = 8'($urandom);
    nack_at = 5;
    tn0 = tn; sp0 = stops;
    do_write(TADDR, 9, 1'b1, 1'b0);
    chk("R8 data nack err", {31'd0, nack_err}, 32'd1);
    chk("R8 bytes until nack", 32'(tn - tn0), 32'd6);
    chk("R8 data nack stop", 32'(stops - sp0), 32'd1);
    chk("R8 window empty", {31'd0, wr_ready}, 32'd1);
    nack_at = -1;
    rseed = 200;
    issue(TADDR, 1, 1'b1, 1'b1);
    chk("R9 active busy", {30'd0, active, cmd_ready}, 32'b10);
    chk("R8 err cleared", {31'd0, nack_err}, 32'd0);
    while (!rd_valid) @(negedge clk);
    chk("R4 single byte", rd_data, {24'd0, rpat(200, 0)});
    rd_ready = 1; @(negedge clk); rd_ready = 0;
    wait_idle();

    // random mix
    for (int n = 0; n < 8; n++) begin
      len = 1 + ($urandom % 12);
      rd = $urandom % 2;
      stp = $urandom % 2;
      sp0 = stops;
      if (rd) begin
        rseed = $urandom % 256;
        do_read(TADDR, len, stp);
      end else begin
        for (int i = 0; i < len; i++) wb[i] = 8'($urandom);
        tn0 = tn;
        do_write(TADDR, len, stp, 1'b0);
        check_write(len, tn0, TADDR);
      end
      if (stp) chk("R2 random stop", 32'(stops - sp0), 32'd1);
      else     chk("R6 random park", {31'd0, parked}, 32'd1);
    end
    if (parked) begin
      issue(TADDR, 0, 1'b0, 1'b1);
      wait_idle();
    end
    chk("R1 released at end", {30'd0, scl_oe, sda_oe}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule